// File: doc/BRIEF.md
# Single-Precision Float to Signed Integer Converter

This block turns a 32-bit IEEE-754 single-precision operand into a signed integer that is either 32 or 64 bits wide. The rounding direction comes either from a 2-bit rounding mode or from the operation select. Four fixed variants ignore the mode: truncate, round-to-nearest, ceiling and floor. All of them share one unpack, round and range-check datapath.

A request is a one-cycle strobe that carries the operand and the controls. The result and its flags are registered and appear one cycle later, together with a one-cycle done pulse. If the rounded value does not fit the target width, or the operand is NaN or infinite, the block raises invalid and returns the largest positive integer of that width. A 64-bit conversion that is not permitted raises an illegal-instruction flag and leaves the held result unchanged.

Top module: `f2i_convert`

## Requirements
- R1: With op_sel = 0, the rounding direction follows rmode: 0 nearest with ties to even, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity. op_sel codes 5 to 7 behave like code 0.
- R2: op_sel 1 (truncate) always rounds toward zero, op_sel 3 (ceiling) toward plus infinity and op_sel 4 (floor) toward minus infinity, whatever rmode holds.
- R3: op_sel 2 (round) always rounds to nearest, whatever rmode holds. Any nearest rounding resolves an exact half toward the even integer.
- R4: With to_wide = 0, a valid result lies in [-2^31, 2^31-1] and is sign-extended to 64 bits. A rounded value outside that range raises invalid and gives 64'h0000_0000_7FFF_FFFF.
- R5: With to_wide = 1, a valid result lies in [-2^63, 2^63-1]. A rounded value outside that range raises invalid and gives 64'h7FFF_FFFF_FFFF_FFFF.
- R6: A NaN or infinite operand (exponent field all ones) raises invalid, clears inexact and gives the largest positive integer of the target width.
- R7: inexact is 1 exactly when nonzero fraction bits were discarded and invalid is 0.
- R8: When to_wide = 1 and wide_ok = 0, illegal is 1, invalid and inexact are 0, and result keeps its previous value. Otherwise illegal is 0 after a request.
- R9: Outputs update one cycle after in_valid, and done pulses high for exactly that cycle. Without a request, result and the flags hold.
- R10: While rst_n is low, result, invalid, inexact, illegal and done are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe, one cycle per conversion |
| operand | input | 32 | Single-precision source value |
| rmode | input | 2 | Rounding mode used by op_sel 0 |
| op_sel | input | 3 | 0 mode-driven, 1 truncate, 2 round, 3 ceiling, 4 floor |
| to_wide | input | 1 | 1 selects a 64-bit target, 0 a 32-bit target |
| wide_ok | input | 1 | 1 when 64-bit conversions are permitted |
| result | output | 64 | Converted integer, held between requests |
| invalid | output | 1 | Overflow, NaN or infinity on the last request |
| inexact | output | 1 | Fraction discarded on the last valid request |
| illegal | output | 1 | Last request was a forbidden 64-bit conversion |
| done | output | 1 | One-cycle pulse marking fresh outputs |

## Verification
Every output of this block is due exactly one cycle after its strobe, because a single register stage sits between the inputs and the ports. The bench drives each request on a falling edge and samples all five outputs on the next falling edge, half a cycle after the capturing rising edge. Hold behaviour and the end of the done pulse are checked on later falling edges, after no new strobe has been given.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  typedef enum logic [1:0] {
    RDIR_NEAR = 2'd0,
    RDIR_ZERO = 2'd1,
    RDIR_UP   = 2'd2,
    RDIR_DOWN = 2'd3
  } rdir_e;

  localparam logic [2:0] OPC_MODE  = 3'd0;
  localparam logic [2:0] OPC_TRUNC = 3'd1;
  localparam logic [2:0] OPC_ROUND = 3'd2;
  localparam logic [2:0] OPC_CEIL  = 3'd3;
  localparam logic [2:0] OPC_FLOOR = 3'd4;

  // Fixed variants override the mode; unknown codes fall back to the mode.
  function automatic rdir_e pick_dir(input logic [2:0] opc, input logic [1:0] mode);
    rdir_e d;
    case (opc)
      OPC_TRUNC: d = RDIR_ZERO;
      OPC_ROUND: d = RDIR_NEAR;
      OPC_CEIL:  d = RDIR_UP;
      OPC_FLOOR: d = RDIR_DOWN;
      default:   d = rdir_e'(mode);
    endcase
    return d;
  endfunction

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack #(
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 23,
  parameter int WIDE_W = 64
) (
  input  logic [EXP_W+MAN_W:0] operand,
  output logic                 sign,
  output logic                 special,
  output logic                 huge,
  output logic [WIDE_W-1:0]    int_part,
  output logic                 guard,
  output logic                 sticky
);
  localparam int FRAC_W = MAN_W + 2;
  localparam int TOT_W  = WIDE_W + FRAC_W;
  localparam int E_W    = EXP_W + 2;
  localparam logic signed [E_W-1:0] BIAS   = E_W'((1 << (EXP_W - 1)) - 1);
  localparam logic signed [E_W-1:0] E_HUGE = E_W'(WIDE_W);
  localparam logic signed [E_W-1:0] E_LOW  = -E_W'(2);
  localparam logic signed [E_W-1:0] TWO    = E_W'(2);

  logic [EXP_W-1:0]        exp_f;
  logic [MAN_W-1:0]        frac_f;
  logic                    norm;
  logic [MAN_W:0]          mant;
  logic [EXP_W-1:0]        exp_eff;
  logic signed [E_W-1:0]   e_unb;
  logic signed [E_W-1:0]   sh_amt;
  logic                    tiny;
  logic [TOT_W-1:0]        fixed;

  assign sign    = operand[EXP_W+MAN_W];
  assign exp_f   = operand[EXP_W+MAN_W-1:MAN_W];
  assign frac_f  = operand[MAN_W-1:0];
  assign norm    = |exp_f;
  assign special = &exp_f;
  assign mant    = {norm, frac_f};
  // Subnormals use the minimum exponent with no hidden bit.
  assign exp_eff = norm ? exp_f : EXP_W'(1);
  assign e_unb   = $signed({2'b00, exp_eff}) - BIAS;
  assign huge    = (e_unb >= E_HUGE);
  assign tiny    = (e_unb < E_LOW);
  assign sh_amt  = e_unb + TWO;

  // Fixed point: WIDE_W integer bits over FRAC_W fraction bits.
  always_comb begin
    fixed = TOT_W'(mant) << $unsigned(sh_amt);
    if (tiny || huge) begin
      int_part = '0;
      guard    = 1'b0;
      sticky   = tiny && (|mant);
    end else begin
      int_part = fixed[TOT_W-1:FRAC_W];
      guard    = fixed[FRAC_W-1];
      sticky   = |fixed[FRAC_W-2:0];
    end
  end

endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import f2i_pkg::*;
#(
  parameter int WIDE_W = 64
) (
  input  logic              sign,
  input  logic [WIDE_W-1:0] int_part,
  input  logic              guard,
  input  logic              sticky,
  input  rdir_e             dir,
  output logic [WIDE_W:0]   mag,
  output logic              lossy
);
  logic bump;

  always_comb begin
    case (dir)
      RDIR_NEAR: bump = guard && (sticky || int_part[0]);
      RDIR_UP:   bump = !sign && (guard || sticky);
      RDIR_DOWN: bump = sign && (guard || sticky);
      default:   bump = 1'b0;
    endcase
  end

  assign lossy = guard || sticky;
  assign mag   = {1'b0, int_part} + {{WIDE_W{1'b0}}, bump};

endmodule

// File: rtl/f2i_pack.sv
module f2i_pack #(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              sign,
  input  logic [WIDE_W:0]   mag,
  input  logic              special,
  input  logic              huge,
  input  logic              to_wide,
  output logic [WIDE_W-1:0] value,
  output logic              bad
);
  localparam logic [WIDE_W:0]   HALF_N = (WIDE_W + 1)'(1) << (NARROW_W - 1);
  localparam logic [WIDE_W:0]   HALF_W = (WIDE_W + 1)'(1) << (WIDE_W - 1);
  localparam logic [WIDE_W-1:0] SAT_N  = {{(WIDE_W - NARROW_W + 1){1'b0}}, {(NARROW_W - 1){1'b1}}};
  localparam logic [WIDE_W-1:0] SAT_W  = {1'b0, {(WIDE_W - 1){1'b1}}};

  logic [WIDE_W:0]   half;
  logic              over;
  logic [WIDE_W-1:0] signed_val;

  assign half = to_wide ? HALF_W : HALF_N;
  // The negative side admits one more magnitude step than the positive side.
  assign over = sign ? (mag > half) : (mag >= half);
  assign bad  = special || huge || over;

  assign signed_val = sign ? (~mag[WIDE_W-1:0] + 1'b1) : mag[WIDE_W-1:0];

  always_comb begin
    if (bad) value = to_wide ? SAT_W : SAT_N;
    else     value = signed_val;
  end

endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
  import f2i_pkg::*;
#(
  parameter int EXP_W    = 8,
  parameter int MAN_W    = 23,
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [EXP_W+MAN_W:0] operand,
  input  logic [1:0]           rmode,
  input  logic [2:0]           op_sel,
  input  logic                 to_wide,
  input  logic                 wide_ok,
  output logic [WIDE_W-1:0]    result,
  output logic                 invalid,
  output logic                 inexact,
  output logic                 illegal,
  output logic                 done
);
  logic              sign;
  logic              special;
  logic              huge;
  logic [WIDE_W-1:0] int_part;
  logic              guard;
  logic              sticky;
  rdir_e             dir;
  logic [WIDE_W:0]   mag;
  logic              lossy;
  logic [WIDE_W-1:0] value;
  logic              bad;
  logic              blocked;

  logic [WIDE_W-1:0] result_d;
  logic              invalid_d;
  logic              inexact_d;
  logic              illegal_d;
  logic              load;

  f2i_unpack #(
    .EXP_W (EXP_W),
    .MAN_W (MAN_W),
    .WIDE_W(WIDE_W)
  ) u_unpack (
    .operand (operand),
    .sign    (sign),
    .special (special),
    .huge    (huge),
    .int_part(int_part),
    .guard   (guard),
    .sticky  (sticky)
  );

  assign dir = pick_dir(op_sel, rmode);

  f2i_round #(
    .WIDE_W(WIDE_W)
  ) u_round (
    .sign    (sign),
    .int_part(int_part),
    .guard   (guard),
    .sticky  (sticky),
    .dir     (dir),
    .mag     (mag),
    .lossy   (lossy)
  );

  f2i_pack #(
    .WIDE_W  (WIDE_W),
    .NARROW_W(NARROW_W)
  ) u_pack (
    .sign   (sign),
    .mag    (mag),
    .special(special),
    .huge   (huge),
    .to_wide(to_wide),
    .value  (value),
    .bad    (bad)
  );

  assign blocked = to_wide && !wide_ok;
  assign load    = in_valid;

  // Next-state: a blocked wide request keeps the old result.
  always_comb begin
    illegal_d = blocked;
    if (blocked) begin
      result_d  = result;
      invalid_d = 1'b0;
      inexact_d = 1'b0;
    end else begin
      result_d  = value;
      invalid_d = bad;
      inexact_d = lossy && !bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result  <= '0;
      invalid <= 1'b0;
      inexact <= 1'b0;
      illegal <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= load;
      if (load) begin
        result  <= result_d;
        invalid <= invalid_d;
        inexact <= inexact_d;
        illegal <= illegal_d;
      end
    end
  end

endmodule

// File: rtl/f2i_convert_chk.sv
module f2i_convert_chk #(
  parameter int EXP_W    = 8,
  parameter int MAN_W    = 23,
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [EXP_W+MAN_W:0] operand,
  input logic                 to_wide,
  input logic                 wide_ok,
  input logic [WIDE_W-1:0]    result,
  input logic                 invalid,
  input logic                 inexact,
  input logic                 illegal,
  input logic                 done
);

  a_r9_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> done);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !done);

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(invalid) && $stable(inexact) && $stable(illegal)));

  a_r8_blocked_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && to_wide && !wide_ok) |=> (illegal && !invalid && !inexact && $stable(result)));

  a_r4_sign_extended: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !to_wide) |=> (result[WIDE_W-1:NARROW_W] == {(WIDE_W - NARROW_W){result[NARROW_W-1]}}));

  a_r6_special_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (&operand[EXP_W+MAN_W-1:MAN_W]) && !(to_wide && !wide_ok)) |=> invalid);

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(invalid && inexact));

  a_r5_saturated_value: assert property (@(posedge clk) disable iff (!rst_n)
    (done && invalid) |-> (!result[WIDE_W-1] && (&result[NARROW_W-2:0])));

endmodule

bind f2i_convert f2i_convert_chk #(
  .EXP_W   (EXP_W),
  .MAN_W   (MAN_W),
  .WIDE_W  (WIDE_W),
  .NARROW_W(NARROW_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .operand (operand),
  .to_wide (to_wide),
  .wide_ok (wide_ok),
  .result  (result),
  .invalid (invalid),
  .inexact (inexact),
  .illegal (illegal),
  .done    (done)
);

// File: tb/sim_f2i_convert.sv
`timescale 1ns/1ps
module sim_f2i_convert;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] operand;
  logic [1:0]  rmode;
  logic [2:0]  op_sel;
  logic        to_wide;
  logic        wide_ok;
  logic [63:0] result;
  logic        invalid;
  logic        inexact;
  logic        illegal;
  logic        done;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;
  logic [63:0] last_res;

  f2i_convert u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .operand (operand),
    .rmode   (rmode),
    .op_sel  (op_sel),
    .to_wide (to_wide),
    .wide_ok (wide_ok),
    .result  (result),
    .invalid (invalid),
    .inexact (inexact),
    .illegal (illegal),
    .done    (done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [67:0] act, input logic [67:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model built from real arithmetic.
  task automatic ref_conv(input logic [31:0] x, input logic [2:0] opc, input logic [1:0] md,
                          input bit wide, output logic [63:0] res, output bit inv, output bit inx);
    int ex;
    int d;
    real v, fl, fr, r, lim;
    ex = int'(x[30:23]);
    case (opc)
      3'd1: d = 1;
      3'd2: d = 0;
      3'd3: d = 2;
      3'd4: d = 3;
      default: d = int'(md);
    endcase
    if (ex == 255) begin
      inv = 1; inx = 0;
      res = wide ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
      return;
    end
    if (ex == 0) v = real'(x[22:0]) * (2.0 ** (-149));
    else         v = real'({1'b1, x[22:0]}) * (2.0 ** (ex - 150));
    if (x[31]) v = -v;
    fl = $floor(v);
    fr = v - fl;
    case (d)
      0: begin
        if (fr > 0.5) r = fl + 1.0;
        else if (fr < 0.5) r = fl;
        else r = ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
      end
      1: r = (v >= 0.0) ? fl : $ceil(v);
      2: r = $ceil(v);
      default: r = fl;
    endcase
    lim = wide ? (2.0 ** 63) : (2.0 ** 31);
    if (r >= lim || r < -lim) begin
      inv = 1; inx = 0;
      res = wide ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
    end else begin
      inv = 0;
      inx = (r != v);
      res = 64'(longint'(r));
    end
  endtask

  task automatic run(input logic [31:0] x, input logic [2:0] opc, input logic [1:0] md,
                     input bit wide, input bit ok, input string tag);
    logic [63:0] e_res;
    bit e_inv, e_inx, e_ill;
    @(negedge clk);
    operand  = x;
    op_sel   = opc;
    rmode    = md;
    to_wide  = wide;
    wide_ok  = ok;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    e_ill = wide && !ok;
    if (e_ill) begin
      e_res = last_res; e_inv = 0; e_inx = 0;
    end else begin
      ref_conv(x, opc, md, wide, e_res, e_inv, e_inx);
    end
    last_res = e_res;
    check($sformatf("%s R9 op=%0d md=%0d w=%0d x=%h", tag, opc, md, wide, x),
          {result, invalid, inexact, illegal, done},
          {e_res, e_inv, e_inx, e_ill, 1'b1});
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd20240607));
    rst_n = 1'b0; in_valid = 1'b0; operand = '0; rmode = '0;
    op_sel = '0; to_wide = 1'b0; wide_ok = 1'b1;
    last_res = '0;
    repeat (3) @(negedge clk);
    check("R10 reset outputs", {result, invalid, inexact, illegal, done}, 68'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 mode-driven on 1.25 and -1.25
    for (int m = 0; m < 4; m++) begin
      run(32'h3FA00000, 3'd0, 2'(m), 0, 1, "R1 +1.25");
      run(32'hBFA00000, 3'd0, 2'(m), 1, 1, "R1 -1.25");
    end
    run(32'hBFA00000, 3'd6, 2'd3, 0, 1, "R1 code6 as mode");
    // R2 fixed directions ignore mode
    run(32'hBFA00000, 3'd1, 2'd3, 0, 1, "R2 trunc");
    run(32'h3FA00000, 3'd3, 2'd1, 0, 1, "R2 ceil");
    run(32'hBFA00000, 3'd4, 2'd2, 1, 1, "R2 floor");
    run(32'hBF000000, 3'd3, 2'd3, 0, 1, "R2 ceil -0.5");
    run(32'h00000001, 3'd3, 2'd0, 0, 1, "R2 ceil subnormal");
    // R3 ties to even
    run(32'h40200000, 3'd2, 2'd1, 0, 1, "R3 2.5");
    run(32'h40600000, 3'd2, 2'd3, 0, 1, "R3 3.5");
    run(32'hC0200000, 3'd0, 2'd0, 1, 1, "R3 -2.5");
    run(32'h3F000000, 3'd2, 2'd2, 0, 1, "R3 0.5");
    run(32'h3FC00000, 3'd2, 2'd0, 0, 1, "R3 1.5");
    // R4 narrow range edges
    run(32'h4F000000, 3'd1, 2'd0, 0, 1, "R4 2^31");
    run(32'hCF000000, 3'd1, 2'd0, 0, 1, "R4 -2^31");
    run(32'h4EFFFFFF, 3'd0, 2'd2, 0, 1, "R4 below 2^31");
    // R5 wide range edges
    run(32'h5F000000, 3'd1, 2'd0, 1, 1, "R5 2^63");
    run(32'hDF000000, 3'd1, 2'd0, 1, 1, "R5 -2^63");
    run(32'h4F000000, 3'd1, 2'd0, 1, 1, "R5 2^31 wide");
    // R6 specials
    run(32'h7FC00000, 3'd0, 2'd0, 0, 1, "R6 NaN");
    run(32'h7F800000, 3'd4, 2'd0, 1, 1, "R6 +inf");
    run(32'hFF800000, 3'd3, 2'd0, 0, 1, "R6 -inf");
    // R7 exact vs inexact
    run(32'h00000000, 3'd0, 2'd0, 0, 1, "R7 zero");
    run(32'h41200000, 3'd0, 2'd2, 0, 1, "R7 exact 10");
    // R8 blocked wide
    run(32'h40600000, 3'd0, 2'd0, 0, 1, "R8 setup");
    run(32'h7FC00000, 3'd2, 2'd0, 1, 0, "R8 blocked");
    run(32'h3FA00000, 3'd1, 2'd0, 0, 0, "R8 narrow allowed");

    // R9 hold and done pulse end
    held = result;
    @(negedge clk);
    @(negedge clk);
    check("R9 idle hold", {result, done}, {held, 1'b0});

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] x;
      logic [7:0]  ex;
      int sel;
      sel = $urandom_range(0, 9);
      if (sel == 0) ex = 8'($urandom);
      else if (sel == 1) ex = 8'($urandom_range(0, 2));
      else ex = 8'($urandom_range(110, 192));
      x = {1'($urandom), ex, 23'($urandom)};
      if ($urandom_range(0, 7) == 0) x[22:0] = {1'b1, 22'd0} >> $urandom_range(0, 22);
      run(x, 3'($urandom), 2'($urandom), 1'($urandom), ($urandom_range(0, 9) != 0), "R1 R2 R3 random");
    end

    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule